// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Flags

This block collects six reset requests (supply power-on level, brown-out level, an active-low external pin, a watchdog timeout pulse, a debug-port request and a software request) and drives four reset domains. The domains are the main logic, the debug port, the pin-override settings and the brown-out configuration. Each source asserts its own subset of those domains. Every asserted domain is held for a fixed stretch after its last request goes away. Assertion follows the requests combinationally, and release happens on a clock edge.

A small register port gives software access to two words. The first is a sticky cause word with one bit per source, which records what reset the device. The second is a control word. Through it software can start a software reset or tell the block to ignore the external pin. The cause word survives every reset except power-on, so software can log the reason for a restart after it comes back up.

Top module: `rst_hub`

## Requirements
- R1: Reading address 0 returns the cause word, with bit 0 for power-on, bit 1 for brown-out, bit 2 for the external pin, bit 3 for watchdog, bit 4 for the debug port and bit 5 for software. Reading address 1 returns the external-pin enable in bit 1 and zero in every other bit.
- R2: While `por_below_i` is high, all four reset outputs are high. When it releases, the cause word holds exactly 6'b000001.
- R3: Each source other than power-on sets only its own cause bit and leaves the other bits alone. Writing 1 to a bit of address 0 clears that bit, and bits written 0 keep their value.
- R4: A brown-out asserts the main, debug and pin-override resets and leaves the brown-out-configuration reset low.
- R5: The external pin passes through a two-flop synchronizer. A low pin raises the main and brown-out-configuration resets after the second clock edge and never before it. It leaves the debug and pin-override resets low.
- R6: Each reset output stays high for exactly 16 clock edges after the last edge at which its request was high. It is low after the 16th such edge.
- R7: Writing 1 to bit 0 of address 1 raises the main reset in the same cycle, before the clock edge. Only the main domain is asserted.
- R8: A one-cycle watchdog pulse asserts the main and brown-out-configuration resets. A debug-port request asserts only the main reset.
- R9: When bit 1 of address 1 is 0, the external pin is ignored: no reset and no cause bit. Any main-domain reset sets this bit back to 1.
- R10: Register writes are ignored while a hardware request or a stretch holds the main reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_below_i | input | 1 | Supply below power-on threshold (active high) |
| bod_below_i | input | 1 | Supply below brown-out level (active high) |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout_i | input | 1 | Watchdog timeout pulse |
| dbg_rst_req_i | input | 1 | Debug-port reset request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address (0 cause word, 1 control) |
| reg_wdata_i | input | 6 | Register write data |
| reg_rdata_o | output | 6 | Register read data for `reg_addr_i` |
| main_rst_o | output | 1 | Main-logic reset |
| dbg_rst_o | output | 1 | Debug-port reset |
| pinovr_rst_o | output | 1 | Pin-override settings reset |
| bodcfg_rst_o | output | 1 | Brown-out configuration reset |

## Verification
The bench builds the block with its defaults: a 16-edge stretch and a two-stage synchronizer. With these values it can count the exact release edge of the stretch and the edge at which a low pin first takes effect. A table walk drives each non-power-on source alone and compares the four outputs with the expected domain subset and the cause word with a single bit. Directed cases then cover accumulation of cause bits, partial clearing, writes dropped during reset, the pin-enable bit and its restore, and a mid-run power-on that wipes the cause word.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;

    localparam int NUM_SRC = 6;
    localparam int NUM_DOM = 4;

    // source positions double as cause-word bit positions
    localparam int SRC_POR = 0;
    localparam int SRC_BOD = 1;
    localparam int SRC_EXT = 2;
    localparam int SRC_WDT = 3;
    localparam int SRC_DBG = 4;
    localparam int SRC_SW  = 5;

    localparam logic ADDR_CAUSE = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;
    localparam int   CTRL_SWRST = 0;
    localparam int   CTRL_EXTEN = 1;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic bodcfg;
        logic pinovr;
        logic dbg;
        logic main;
    } dom_t;

    function automatic dom_t src_domains(input int s);
        dom_t m;
        m = '0;
        case (s)
            SRC_POR: m = '{bodcfg: 1'b1, pinovr: 1'b1, dbg: 1'b1, main: 1'b1};
            SRC_BOD: m = '{bodcfg: 1'b0, pinovr: 1'b1, dbg: 1'b1, main: 1'b1};
            SRC_EXT: m = '{bodcfg: 1'b1, pinovr: 1'b0, dbg: 1'b0, main: 1'b1};
            SRC_WDT: m = '{bodcfg: 1'b1, pinovr: 1'b0, dbg: 1'b0, main: 1'b1};
            default: m = '{bodcfg: 1'b0, pinovr: 1'b0, dbg: 1'b0, main: 1'b1};
        endcase
        return m;
    endfunction

    function automatic dom_t domain_request(input src_vec_t v);
        dom_t m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (v[s]) m = m | src_domains(s);
        end
        return m;
    endfunction

endpackage

// File: rtl/rst_hub_sync.sv
module rst_hub_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= {STAGES{RST_VAL}};
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_hub_stretch.sv
module rst_hub_stretch #(
    parameter int STRETCH = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    output logic busy_o,
    output logic rst_o
);
    localparam int CNT_W = $clog2(STRETCH + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || req_i)   cnt_q <= CNT_W'(STRETCH);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
    assign rst_o  = req_i | busy_o;

    // R6: a released request keeps the reset up for the following cycle
    a_r6_hold_after_release: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(req_i) && !req_i) |-> rst_o);
endmodule

// File: rtl/rst_hub_cause.sv
module rst_hub_cause
    import rst_hub_pkg::*;
(
    input  logic               clk_i,
    input  logic               por_i,
    input  src_vec_t           src_i,
    input  logic               main_rst_i,
    input  logic               wr_i,
    input  logic               addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               sw_req_o,
    output logic               ext_en_o
);
    src_vec_t flags_q;
    src_vec_t clr;
    logic     ext_en_q;

    always_comb begin
        clr = '0;
        if (wr_i && addr_i == ADDR_CAUSE) clr = wdata_i;
    end

    assign sw_req_o = wr_i && (addr_i == ADDR_CTRL) && wdata_i[CTRL_SWRST];

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            flags_q          <= '0;
            flags_q[SRC_POR] <= 1'b1;
        end else begin
            flags_q <= (flags_q & ~clr) | src_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (main_rst_i)                         ext_en_q <= 1'b1;
        else if (wr_i && addr_i == ADDR_CTRL)   ext_en_q <= wdata_i[CTRL_EXTEN];
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CAUSE) rdata_o = flags_q;
        else                      rdata_o[CTRL_EXTEN] = ext_en_q;
    end

    assign ext_en_o = ext_en_q;

    // R2: the first cycle after power-on release shows only the power-on bit
    a_r2_por_only_flag: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(por_i) |-> (flags_q == src_vec_t'(1)));

    // R3: without a clearing write no cause bit drops
    a_r3_flags_sticky: assert property (@(posedge clk_i) disable iff (por_i)
        (clr == '0) |=> (($past(flags_q) & ~flags_q) == '0));
endmodule

// File: rtl/rst_hub.sv
module rst_hub
    import rst_hub_pkg::*;
#(
    parameter int STRETCH     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               por_below_i,
    input  logic               bod_below_i,
    input  logic               ext_rst_n_i,
    input  logic               wdt_timeout_i,
    input  logic               dbg_rst_req_i,
    input  logic               reg_wr_i,
    input  logic               reg_addr_i,
    input  logic [NUM_SRC-1:0] reg_wdata_i,
    output logic [NUM_SRC-1:0] reg_rdata_o,
    output logic               main_rst_o,
    output logic               dbg_rst_o,
    output logic               pinovr_rst_o,
    output logic               bodcfg_rst_o
);
    logic               pin_s;
    logic               ext_en;
    logic               sw_req;
    logic               write_ok;
    src_vec_t           hw_src;
    src_vec_t           all_src;
    dom_t               dom_req;
    logic [NUM_DOM-1:0] dom_req_v;
    logic [NUM_DOM-1:0] dom_busy;
    logic [NUM_DOM-1:0] dom_rst;

    rst_hub_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk_i (clk_i),
        .rst_i (por_below_i),
        .d_i   (ext_rst_n_i),
        .q_o   (pin_s)
    );

    always_comb begin
        hw_src          = '0;
        hw_src[SRC_POR] = por_below_i;
        hw_src[SRC_BOD] = bod_below_i;
        hw_src[SRC_EXT] = ext_en & ~pin_s;
        hw_src[SRC_WDT] = wdt_timeout_i;
        hw_src[SRC_DBG] = dbg_rst_req_i;
        all_src         = hw_src;
        all_src[SRC_SW] = sw_req;
    end

    // every source reaches the main domain, so any busy stretch means main is held
    assign write_ok  = ~((|hw_src) | (|dom_busy));
    assign dom_req   = domain_request(all_src);
    assign dom_req_v = dom_req;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        rst_hub_stretch #(.STRETCH(STRETCH)) u_stretch (
            .clk_i  (clk_i),
            .rst_i  (por_below_i),
            .req_i  (dom_req_v[d]),
            .busy_o (dom_busy[d]),
            .rst_o  (dom_rst[d])
        );
    end

    assign main_rst_o   = dom_rst[0];
    assign dbg_rst_o    = dom_rst[1];
    assign pinovr_rst_o = dom_rst[2];
    assign bodcfg_rst_o = dom_rst[3];

    rst_hub_cause u_cause (
        .clk_i      (clk_i),
        .por_i      (por_below_i),
        .src_i      (all_src),
        .main_rst_i (main_rst_o),
        .wr_i       (reg_wr_i & write_ok),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .sw_req_o   (sw_req),
        .ext_en_o   (ext_en)
    );

    // R4: the debug domain rises only on a brown-out (power-on is excluded by disable)
    a_r4_dbg_rise_supply: assert property (@(posedge clk_i) disable iff (por_below_i)
        $rose(dbg_rst_o) |-> bod_below_i);

    // R7: an accepted software request has the main reset up in its own cycle
    a_r7_sw_immediate: assert property (@(posedge clk_i) disable iff (por_below_i)
        sw_req |-> main_rst_o);
endmodule

// File: tb/rst_hub_tb_top.sv
`timescale 1ns/1ps
module rst_hub_tb_top;
    logic       clk = 1'b0;
    logic       por, bod, ext_n, wdt, dbg, wr, addr;
    logic [5:0] wdata, rdata;
    logic       m_rst, d_rst, p_rst, b_rst;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;
    logic [5:0] rv;

    always #2.5 clk = ~clk;

    rst_hub dut_i (
        .clk_i(clk), .por_below_i(por), .bod_below_i(bod), .ext_rst_n_i(ext_n),
        .wdt_timeout_i(wdt), .dbg_rst_req_i(dbg), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .main_rst_o(m_rst),
        .dbg_rst_o(d_rst), .pinovr_rst_o(p_rst), .bodcfg_rst_o(b_rst)
    );

    // entry: source code [12:10], domain mask {bodcfg,pinovr,dbg,main} [9:6], cause [5:0]
    localparam logic [12:0] VEC [5] = '{
        {3'd1, 4'b0111, 6'b000010},
        {3'd2, 4'b1001, 6'b000100},
        {3'd3, 4'b1001, 6'b001000},
        {3'd4, 4'b0001, 6'b010000},
        {3'd5, 4'b0001, 6'b100000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [5:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic a, output logic [5:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [3:0] mask();
        return {b_rst, p_rst, d_rst, m_rst};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        por = 1; bod = 0; ext_n = 1; wdt = 0; dbg = 0; wr = 0; addr = 0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R2 all domains in power-on", 32'(mask()), 32'hF);
        por = 0;
        repeat (22) @(negedge clk);
        chk("R6 outputs released", 32'(mask()), 32'h0);
        rd_reg(1'b0, rv); chk("R2 R1 cause after power-on", 32'(rv), 32'h01);
        rd_reg(1'b1, rv); chk("R1 R9 control default", 32'(rv), 32'h02);

        // table walk: one source at a time
        for (int i = 0; i < 5; i++) begin
            wr_reg(1'b0, 6'h3F);
            rd_reg(1'b0, rv); chk("R3 cause cleared", 32'(rv), 32'h0);
            case (VEC[i][12:10])
                3'd1: begin bod = 1; repeat (3) @(negedge clk); end
                3'd2: begin ext_n = 0; repeat (3) @(negedge clk); end
                3'd3: begin wdt = 1; @(negedge clk); wdt = 0; end
                3'd4: begin dbg = 1; repeat (3) @(negedge clk); end
                default: wr_reg(1'b1, 6'h01);
            endcase
            chk("R4 R5 R7 R8 domain subset", 32'(mask()), 32'(VEC[i][9:6]));
            bod = 0; ext_n = 1; dbg = 0;
            repeat (22) @(negedge clk);
            chk("R6 released after source", 32'(mask()), 32'h0);
            rd_reg(1'b0, rv); chk("R3 own cause bit", 32'(rv), 32'(VEC[i][5:0]));
        end

        // R6: exact stretch length
        dbg = 1; @(negedge clk); dbg = 0;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk); chk("R6 held during stretch", 32'(m_rst), 32'h1);
        end
        @(negedge clk); chk("R6 released at 16th edge", 32'(m_rst), 32'h0);

        // R5: synchronizer latency
        wr_reg(1'b0, 6'h3F);
        ext_n = 0;
        #1 chk("R5 no reset before first edge", 32'(m_rst), 32'h0);
        @(negedge clk); chk("R5 no reset after first edge", 32'(m_rst), 32'h0);
        @(negedge clk); chk("R5 reset after second edge", 32'(mask()), 32'h9);
        ext_n = 1;
        repeat (22) @(negedge clk);

        // R3: accumulation and partial clear
        wdt = 1; @(negedge clk); wdt = 0;
        repeat (22) @(negedge clk);
        rd_reg(1'b0, rv); chk("R3 bits accumulate", 32'(rv), 32'h0C);
        wr_reg(1'b0, 6'h08);
        rd_reg(1'b0, rv); chk("R3 partial clear", 32'(rv), 32'h04);

        // R10: writes dropped while held in reset
        bod = 1; repeat (2) @(negedge clk);
        wr_reg(1'b0, 6'h3F);
        rd_reg(1'b0, rv); chk("R10 clear ignored during request", 32'(rv), 32'h06);
        bod = 0; @(negedge clk);
        wr_reg(1'b0, 6'h3F);
        repeat (22) @(negedge clk);
        rd_reg(1'b0, rv); chk("R10 clear ignored during stretch", 32'(rv), 32'h06);
        wr_reg(1'b0, 6'h3F);

        // R9: pin disabled, then restored by a main reset
        wr_reg(1'b1, 6'h00);
        rd_reg(1'b1, rv); chk("R9 enable cleared", 32'(rv), 32'h0);
        ext_n = 0; repeat (5) @(negedge clk);
        chk("R9 pin ignored", 32'(mask()), 32'h0);
        rd_reg(1'b0, rv); chk("R9 no pin cause", 32'(rv), 32'h0);
        ext_n = 1; repeat (3) @(negedge clk);
        wr_reg(1'b1, 6'h01);
        repeat (22) @(negedge clk);
        rd_reg(1'b1, rv); chk("R9 enable restored by reset", 32'(rv), 32'h02);

        // R2: power-on mid-run wipes other causes
        bod = 1; @(negedge clk); bod = 0;
        por = 1; @(negedge clk);
        chk("R2 power-on asserts all", 32'(mask()), 32'hF);
        por = 0; repeat (22) @(negedge clk);
        rd_reg(1'b0, rv); chk("R2 only power-on cause", 32'(rv), 32'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule